// File: doc/BRIEF.md
# Shift, Rotate and Nibble-Swap Unit

This block is the shifting slice of a processor ALU. It takes one register operand, a three-bit operation code and the current status byte. It returns the shifted result and an updated status byte. It covers logical shifts in both directions, rotates through the carry flag in both directions, an arithmetic right shift that keeps the sign bit, and an exchange of the operand's two halves. The whole path is combinational, so the result and the flags are ready in the same cycle the inputs are applied.

The incoming carry is read from the carry position of the status byte. Every shift and rotate rewrites carry, zero, negative, overflow and sign. Overflow comes from the result sign and the new carry, and sign comes from negative and overflow. Half-carry, bit-copy and interrupt-enable pass through untouched. The half swap and the two spare operation codes leave the whole status byte as it came in. The operand width is a parameter with a default of 8 bits.

Top module: `shifter_unit`

## Requirements
- R1: Operation code 0 (shift left) gives result = operand shifted up one place with 0 in bit 0, and new C = old operand MSB.
- R2: Operation code 1 (logical shift right) gives result = operand shifted down one place with 0 in the MSB, and new C = old operand bit 0.
- R3: Operation code 2 (rotate left) gives result = operand shifted up one place with the incoming C in bit 0, and new C = old operand MSB.
- R4: Operation code 3 (rotate right) gives result = operand shifted down one place with the incoming C in the MSB, and new C = old operand bit 0.
- R5: Operation code 4 (arithmetic shift right) gives result = operand shifted down one place with the MSB kept at its old value, and new C = old operand bit 0.
- R6: For codes 0 to 4, Z (status bit 1) is 1 exactly when the result is all zeros, and N (status bit 2) equals the result MSB.
- R7: For codes 0 to 4, V (status bit 3) = N XOR new C, and S (status bit 4) = N XOR V.
- R8: Operation code 5 exchanges the lower and upper halves of the operand, and the status output equals the status input in all 8 bits.
- R9: H, T and I (status bits 5, 6, 7) equal their inputs for every operation code.
- R10: Operation codes 6 and 7 return the operand unchanged, and the status output equals the status input.
- R11: The result and the status output follow the inputs within the same clock cycle, with no register on the path. The incoming C is status bit 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_i | input | WIDTH | Register operand |
| op_i | input | 3 | Operation code (0 shl, 1 lshr, 2 rol, 3 ror, 4 ashr, 5 swap, 6-7 spare) |
| stat_i | input | 8 | Status byte in: bit0 C, 1 Z, 2 N, 3 V, 4 S, 5 H, 6 T, 7 I |
| res_o | output | WIDTH | Shifted result |
| stat_o | output | 8 | Updated status byte, same bit positions |

## Verification
Each code is tried with operands at the edges: all zeros, all ones, only the MSB set, only bit 0 set, and alternating patterns. Each of these is run with the incoming carry both clear and set. A carry that leaks into a logical shift, or is missing from a rotate, shows up here. So does an arithmetic shift that loses the sign, or a shift that puts a value into Z while shifting to zero. A sweep of random operands, codes and full status bytes is then compared every clock against a behavioural model. That sweep separates the overflow and sign rules from one another and confirms that the swap, the spare codes and the H/T/I bits never disturb the status byte.

// File: rtl/shf_pkg.sv
package shf_pkg;

   typedef enum logic [2:0] {
      SH_LSL  = 3'd0,
      SH_LSR  = 3'd1,
      SH_ROL  = 3'd2,
      SH_ROR  = 3'd3,
      SH_ASR  = 3'd4,
      SH_SWAP = 3'd5,
      SH_RSV6 = 3'd6,
      SH_RSV7 = 3'd7
   } shf_op_e;

   localparam int STAT_W = 8;
   localparam int FL_C   = 0;
   localparam int FL_Z   = 1;
   localparam int FL_N   = 2;
   localparam int FL_V   = 3;
   localparam int FL_S   = 4;
   localparam int FL_H   = 5;
   localparam int FL_T   = 6;
   localparam int FL_I   = 7;

endpackage

// File: rtl/shf_datapath.sv
module shf_datapath
   import shf_pkg::*;
#(
   parameter int WIDTH = 8
) (
   input  logic [WIDTH-1:0] opnd_i,
   input  shf_op_e          op_i,
   input  logic             cin_i,
   output logic [WIDTH-1:0] res_o,
   output logic             cout_o,
   output logic             upd_o
);

   localparam int HALF = WIDTH / 2;
   localparam int MSB  = WIDTH - 1;

   logic             fill_lo;
   logic             fill_hi;
   logic [WIDTH-1:0] up_v;
   logic [WIDTH-1:0] dn_v;
   logic [WIDTH-1:0] sw_v;

   // bits entering at either end depend on the operation
   always_comb begin
      fill_lo = (op_i == SH_ROL) ? cin_i : 1'b0;
      unique case (op_i)
         SH_ROR:  fill_hi = cin_i;
         SH_ASR:  fill_hi = opnd_i[MSB];
         default: fill_hi = 1'b0;
      endcase
   end

   for (genvar b = 0; b < WIDTH; b++) begin : g_bit
      if (b == 0) begin : g_lo
         assign up_v[b] = fill_lo;
      end else begin : g_lo_mid
         assign up_v[b] = opnd_i[b-1];
      end
      if (b == MSB) begin : g_hi
         assign dn_v[b] = fill_hi;
      end else begin : g_hi_mid
         assign dn_v[b] = opnd_i[b+1];
      end
      assign sw_v[b] = opnd_i[(b + HALF) % WIDTH];
   end

   always_comb begin
      res_o  = opnd_i;
      cout_o = cin_i;
      upd_o  = 1'b0;
      unique case (op_i)
         SH_LSL, SH_ROL: begin
            res_o  = up_v;
            cout_o = opnd_i[MSB];
            upd_o  = 1'b1;
         end
         SH_LSR, SH_ROR, SH_ASR: begin
            res_o  = dn_v;
            cout_o = opnd_i[0];
            upd_o  = 1'b1;
         end
         SH_SWAP: res_o = sw_v;
         default: res_o = opnd_i;
      endcase
   end

endmodule

// File: rtl/shf_flags.sv
module shf_flags
   import shf_pkg::*;
#(
   parameter int WIDTH = 8
) (
   input  logic [WIDTH-1:0]  res_i,
   input  logic              cout_i,
   input  logic              upd_i,
   input  logic [STAT_W-1:0] stat_i,
   output logic [STAT_W-1:0] stat_o
);

   logic zf;
   logic nf;
   logic vf;
   logic sf;

   assign zf = ~|res_i;
   assign nf = res_i[WIDTH-1];
   assign vf = nf ^ cout_i;
   assign sf = nf ^ vf;

   always_comb begin
      stat_o = stat_i;
      if (upd_i) begin
         stat_o[FL_C] = cout_i;
         stat_o[FL_Z] = zf;
         stat_o[FL_N] = nf;
         stat_o[FL_V] = vf;
         stat_o[FL_S] = sf;
      end
   end

endmodule

// File: rtl/shifter_unit.sv
module shifter_unit
   import shf_pkg::*;
#(
   parameter int WIDTH = 8
) (
   input  logic [WIDTH-1:0]  opnd_i,
   input  logic [2:0]        op_i,
   input  logic [STAT_W-1:0] stat_i,
   output logic [WIDTH-1:0]  res_o,
   output logic [STAT_W-1:0] stat_o
);

   if (WIDTH < 2 || (WIDTH % 2) != 0) begin : g_bad_width
      $error("shifter_unit: WIDTH must be even and at least 2");
   end

   shf_op_e          op_e;
   logic [WIDTH-1:0] res_w;
   logic             cout_w;
   logic             upd_w;

   assign op_e = shf_op_e'(op_i);

   shf_datapath #(.WIDTH(WIDTH)) u_dp (
      .opnd_i (opnd_i),
      .op_i   (op_e),
      .cin_i  (stat_i[FL_C]),
      .res_o  (res_w),
      .cout_o (cout_w),
      .upd_o  (upd_w)
   );

   shf_flags #(.WIDTH(WIDTH)) u_fl (
      .res_i  (res_w),
      .cout_i (cout_w),
      .upd_i  (upd_w),
      .stat_i (stat_i),
      .stat_o (stat_o)
   );

   assign res_o = res_w;

endmodule

// File: rtl/shifter_unit_chk.sv
module shifter_unit_chk
   import shf_pkg::*;
#(
   parameter int WIDTH = 8
) (
   input logic [WIDTH-1:0]  opnd_i,
   input logic [2:0]        op_i,
   input logic [STAT_W-1:0] stat_i,
   input logic [WIDTH-1:0]  res_o,
   input logic [STAT_W-1:0] stat_o
);

   logic shift_op;
   assign shift_op = (op_i <= 3'd4);

   always_comb begin
      if (op_i == 3'd0)
         AST_LSL_CARRY: assert (stat_o[FL_C] == opnd_i[WIDTH-1] && res_o[0] == 1'b0); // R1
      if (op_i == 3'd3)
         AST_ROR_FILL: assert (res_o[WIDTH-1] == stat_i[FL_C] && stat_o[FL_C] == opnd_i[0]); // R4
      if (op_i == 3'd4)
         AST_ASR_SIGN: assert (res_o[WIDTH-1] == opnd_i[WIDTH-1]); // R5
      if (shift_op)
         AST_ZERO_NEG: assert (stat_o[FL_Z] == (res_o == '0) && stat_o[FL_N] == res_o[WIDTH-1]); // R6
      if (shift_op)
         AST_OVF_SIGN: assert (stat_o[FL_V] == (res_o[WIDTH-1] ^ stat_o[FL_C])
                               && stat_o[FL_S] == (stat_o[FL_N] ^ stat_o[FL_V])); // R7
      if (op_i == 3'd5)
         AST_SWAP_KEEP: assert (stat_o == stat_i); // R8
      AST_HTI_PASS: assert (stat_o[7:5] == stat_i[7:5]); // R9
      if (op_i >= 3'd6)
         AST_SPARE_IDLE: assert (res_o == opnd_i && stat_o == stat_i); // R10
   end

endmodule

bind shifter_unit shifter_unit_chk #(.WIDTH(WIDTH)) u_chk (
   .opnd_i (opnd_i),
   .op_i   (op_i),
   .stat_i (stat_i),
   .res_o  (res_o),
   .stat_o (stat_o)
);

// File: tb/shifter_unit_tb.sv
module shifter_unit_tb;

   logic       clk = 1'b0;
   logic [7:0] opnd;
   logic [2:0] op;
   logic [7:0] st;
   logic [7:0] res;
   logic [7:0] sto;
   int         checks = 0;
   int         errors = 0;

   always #4 clk = ~clk;

   shifter_unit #(.WIDTH(8)) u_dut (
      .opnd_i (opnd),
      .op_i   (op),
      .stat_i (st),
      .res_o  (res),
      .stat_o (sto)
   );

   function automatic void model(input int o, input int a, input int s,
                                 output int r, output int so);
      int c;
      int nc;
      int n;
      int v;
      c  = s % 2;
      so = s;
      nc = 0;
      case (o)
         0: begin r = (a * 2) % 256;              nc = a / 128; end
         1: begin r = a / 2;                      nc = a % 2;   end
         2: begin r = (a * 2) % 256 + c;          nc = a / 128; end
         3: begin r = a / 2 + c * 128;            nc = a % 2;   end
         4: begin r = a / 2 + (a / 128) * 128;    nc = a % 2;   end
         5: begin r = (a % 16) * 16 + a / 16;                   end
         default: r = a;
      endcase
      if (o <= 4) begin
         n  = r / 128;
         v  = (n != nc) ? 1 : 0;
         so = (s / 32) * 32;
         so = so + nc + ((r == 0) ? 2 : 0) + n * 4 + v * 8 + ((n != v) ? 16 : 0);
      end
   endfunction

   task automatic check(input string tag, input int got, input int exp);
      checks++;
      if (got != exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, got, exp);
      end
   endtask

   task automatic apply(input int o, input int a, input int s);
      int er;
      int es;
      string rt;
      @(posedge clk);
      #1;
      op   = 3'(o);
      opnd = 8'(a);
      st   = 8'(s);
      model(o, a, s, er, es);
      case (o)
         0: rt = "R1";
         1: rt = "R2";
         2: rt = "R3";
         3: rt = "R4";
         4: rt = "R5";
         5: rt = "R8";
         default: rt = "R10";
      endcase
      @(negedge clk);
      // R11: sampled in the same cycle the inputs were applied
      check({rt, " R11 result"}, int'(res), er);
      check({rt, " carry"}, int'(sto[0]), es % 2);
      check("R6 zero/neg", int'(sto[2:1]), (es / 2) % 4);
      check("R7 ovf/sign", int'(sto[4:3]), (es / 8) % 4);
      check("R9 H/T/I", int'(sto[7:5]), s / 32);
      if (o >= 5) check({rt, " status kept"}, int'(sto), s);
   endtask

   initial begin
      #(8 * 200000);
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      int pats[6];
      pats = '{8'h00, 8'hFF, 8'h80, 8'h01, 8'hA5, 8'h5A};
      opnd = '0;
      op   = '0;
      st   = '0;
      @(negedge clk);
      check("R1 idle result", int'(res), 0);
      check("R6 idle status", int'(sto), 8'h02);
      for (int o = 0; o < 8; o++)
         for (int p = 0; p < 6; p++)
            for (int c = 0; c < 2; c++)
               apply(o, pats[p], c == 0 ? 8'h00 : 8'hE1);
      for (int k = 0; k < 600; k++)
         apply($urandom_range(0, 7), $urandom_range(0, 255), $urandom_range(0, 255));
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule